// File: doc/BRIEF.md
# Pointer-Chasing DMA Engine

This block is a single-channel DMA engine that moves data through a table of pointers rather than from a flat source buffer. For each element it first fetches a 32-bit pointer from the table address held in its source register. It then reads the data word or byte that the pointer names. Last, it writes that value to the destination address. A table of N pointers gathers N scattered values into one destination buffer, or into one fixed destination location.

The memory side is a simple synchronous master port on a 16-bit bus. It has an address, separate read and write strobes, two byte enables, read data, write data and a ready input that stretches any access. Software places the table address, destination address, element count, data size and a destination-increment flag on the configuration inputs. It then pulses `start`. The engine captures the configuration at that moment, raises `busy` while it works, and raises `done` when the last write is accepted. A size code that the indirect mode cannot handle raises `err` instead, and the engine makes no bus access.

Controller states: `ST_IDLE`, `ST_PTR_HI` (upper pointer half read), `ST_PTR_LO` (lower pointer half read), `ST_DATA_RD` (data read through the pointer) and `ST_DATA_WR` (data write to the destination). Transitions: IDLE→PTR_HI on an accepted start; PTR_HI→PTR_LO, PTR_LO→DATA_RD and DATA_RD→DATA_WR, each on ready; DATA_WR→PTR_HI on ready when more elements remain; DATA_WR→IDLE on ready after the last element. Every non-idle state holds in place while ready is low.

Top module: `ptr_dma_engine`

## Requirements
- R1: After reset the engine is idle: `mem_rd`, `mem_wr`, `busy`, `done` and `err` are all 0.
- R2: Each element begins with two 16-bit reads, both with `mem_be` = 2'b11. The first read is at the table address and returns the upper pointer half. The second read is at the table address + 2 and returns the lower half. In each half, lane 0 (bits 7:0) is the byte at the even address.
- R3: The third access is a read whose address is the full 32-bit pointer assembled from the two halves.
- R4: The fourth access is a write to the destination address of the value read through the pointer. A 16-bit value goes out whole with `mem_be` = 2'b11. An 8-bit value is copied onto both bytes of `mem_wdata`, and `mem_be` enables lane 0 for an even destination address and lane 1 for an odd one.
- R5: With size 8-bit, the data read enables only the lane given by pointer bit 0 (2'b01 for even, 2'b10 for odd), and the byte taken is the one from that lane.
- R6: The table address advances by 4 after every completed element.
- R7: With the increment flag set, the destination advances by 1 (8-bit) or 2 (16-bit) per element. With the flag clear, every write goes to the same address.
- R8: After `cfg_count` completed writes, `done` is 1 and `busy` is 0 from the cycle after the last write is accepted. `done` stays set until the next start, and `done` is 0 while `busy` is 1.
- R9: While an access waits for `mem_ready`, its address, strobes, byte enables and write data stay unchanged. Read and write are never asserted together.
- R10: Size codes are 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = reserved, 2'b11 = 16-byte. A start with 2'b10 or 2'b11 sets `err`, leaves `done` at 0 and makes no bus access. `err` holds until the next start.
- R11: A start with `cfg_count` = 0 sets `done` on the next cycle without any bus access.
- R12: While `busy`, the `start` input and all configuration inputs are ignored. This also holds when `start` coincides with the acceptance of the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| cfg_src | input | 32 | Pointer table address |
| cfg_dst | input | 32 | Destination address |
| cfg_count | input | 16 | Number of elements |
| cfg_size | input | 2 | Data size code (see R10) |
| cfg_dst_inc | input | 1 | Advance destination after each element |
| mem_addr | output | 32 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Access completes on a clock edge where this is 1 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed |
| err | output | 1 | Last start had an unsupported size |

## Verification
Two things can land on the same clock edge: a new `start` request, and the acceptance of the final destination write that ends a run. The bench provokes this by raising `start` exactly when it grants ready to the last queued write. The edge then has to report completion (`done` high, `busy` low) and must not launch a second run, so no further bus access may appear. A second provocation issues `start` with different configuration in the middle of a run with random ready stalls. The reference model's access queue, checked on every clock, then shows that the original run continued unchanged.

// File: rtl/ptr_dma_pkg.sv
package ptr_dma_pkg;

    localparam int unsigned BUS_W = 16;
    localparam int unsigned LANES = BUS_W / 8;
    localparam int unsigned LSB_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR_HI,
        ST_PTR_LO,
        ST_DATA_RD,
        ST_DATA_WR
    } dma_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_RSVD  = 2'b10,
        SZ_BLK16 = 2'b11
    } dma_size_t;

endpackage

// File: rtl/ptr_dma_lane.sv
module ptr_dma_lane
    import ptr_dma_pkg::*;
(
    input  logic             byte_access,
    input  logic [LSB_W-1:0] addr_lsb,
    input  logic [BUS_W-1:0] rdata_raw,
    input  logic [BUS_W-1:0] hold_data,
    output logic [LANES-1:0] be,
    output logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata_steer
);

    always_comb begin
        if (byte_access) begin
            be          = LANES'(1) << addr_lsb;
            rdata_steer = BUS_W'(rdata_raw[addr_lsb*8 +: 8]);
        end else begin
            be          = '1;
            rdata_steer = rdata_raw;
        end
    end

    // a byte is replicated on every lane, a wider value keeps its lanes
    for (genvar g = 0; g < LANES; g++) begin : g_wlane
        assign wdata[g*8 +: 8] = byte_access ? hold_data[7:0] : hold_data[g*8 +: 8];
    end

endmodule

// File: rtl/ptr_dma_ctrl.sv
module ptr_dma_ctrl
    import ptr_dma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned PTR_W = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_size,
    input  logic             cfg_dst_inc,
    input  logic             mem_ready,
    input  logic [BUS_W-1:0] rdata_raw,
    input  logic [BUS_W-1:0] rdata_steer,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             byte_access,
    output logic [BUS_W-1:0] hold_data,
    output logic             busy,
    output logic             done,
    output logic             err
);

    localparam int unsigned PTR_STEP  = PTR_W / 8;
    localparam int unsigned HALF_STEP = BUS_W / 8;

    dma_state_t       st_q, st_nx;
    logic [AW-1:0]    src_q, dst_q;
    logic [PTR_W-1:0] ptr_q;
    logic [BUS_W-1:0] dat_q;
    logic [CNT_W-1:0] cnt_q;
    logic             byte_q, inc_q, done_q, err_q;
    logic             size_ok, last_elem, data_phase;

    assign size_ok   = (cfg_size == SZ_BYTE) || (cfg_size == SZ_HALF);
    assign last_elem = (cnt_q == CNT_W'(1));

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:    if (start && size_ok && (cfg_count != '0)) st_nx = ST_PTR_HI;
            ST_PTR_HI:  if (mem_ready) st_nx = ST_PTR_LO;
            ST_PTR_LO:  if (mem_ready) st_nx = ST_DATA_RD;
            ST_DATA_RD: if (mem_ready) st_nx = ST_DATA_WR;
            ST_DATA_WR: if (mem_ready) st_nx = last_elem ? ST_IDLE : ST_PTR_HI;
            default:    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            ptr_q  <= '0;
            dat_q  <= '0;
            cnt_q  <= '0;
            byte_q <= 1'b0;
            inc_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    done_q <= (cfg_count == '0) && size_ok;
                    err_q  <= !size_ok;
                    src_q  <= cfg_src;
                    dst_q  <= cfg_dst;
                    cnt_q  <= cfg_count;
                    byte_q <= (cfg_size == SZ_BYTE);
                    inc_q  <= cfg_dst_inc;
                end
                ST_PTR_HI:  if (mem_ready) ptr_q[PTR_W-1 -: BUS_W] <= rdata_raw;
                ST_PTR_LO:  if (mem_ready) ptr_q[BUS_W-1:0] <= rdata_raw;
                ST_DATA_RD: if (mem_ready) dat_q <= rdata_steer;
                ST_DATA_WR: if (mem_ready) begin
                    src_q <= src_q + AW'(PTR_STEP);
                    if (inc_q) dst_q <= dst_q + (byte_q ? AW'(1) : AW'(HALF_STEP));
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (last_elem) done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_addr   = '0;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        data_phase = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_PTR_HI: begin
                mem_rd   = 1'b1;
                mem_addr = src_q;
            end
            ST_PTR_LO: begin
                mem_rd   = 1'b1;
                mem_addr = src_q + AW'(HALF_STEP);
            end
            ST_DATA_RD: begin
                mem_rd     = 1'b1;
                mem_addr   = AW'(ptr_q);
                data_phase = 1'b1;
            end
            ST_DATA_WR: begin
                mem_wr     = 1'b1;
                mem_addr   = dst_q;
                data_phase = 1'b1;
            end
            default: ;
        endcase
    end

    assign byte_access = data_phase && byte_q;
    assign hold_data   = dat_q;
    assign busy        = (st_q != ST_IDLE);
    assign done        = done_q;
    assign err         = err_q;

    // R9: a stalled access keeps its address and strobes
    assert_hold_while_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) && !mem_ready |=> $stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr));

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2: the lower pointer half is read right after the upper one, two bytes above
    assert_ptr_lo_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PTR_HI) && mem_ready |=> mem_rd && (mem_addr == $past(mem_addr) + AW'(HALF_STEP)));

    // R10: an unsupported size raises the error and starts no access
    assert_reject_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) && start && !size_ok |=> err && !mem_rd && !mem_wr && !busy);

    // R8: completion follows an accepted write, unless the count was zero (R11)
    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_wr && mem_ready) || $past(start && !busy));

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

endmodule

// File: rtl/ptr_dma_engine.sv
module ptr_dma_engine
    import ptr_dma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned PTR_W = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_size,
    input  logic             cfg_dst_inc,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [LANES-1:0] mem_be,
    output logic [BUS_W-1:0] mem_wdata,
    input  logic [BUS_W-1:0] mem_rdata,
    input  logic             mem_ready,
    output logic             busy,
    output logic             done,
    output logic             err
);

    logic             byte_access;
    logic [BUS_W-1:0] hold_data;
    logic [BUS_W-1:0] rdata_steer;

    ptr_dma_ctrl #(
        .AW    (AW),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_src     (cfg_src),
        .cfg_dst     (cfg_dst),
        .cfg_count   (cfg_count),
        .cfg_size    (cfg_size),
        .cfg_dst_inc (cfg_dst_inc),
        .mem_ready   (mem_ready),
        .rdata_raw   (mem_rdata),
        .rdata_steer (rdata_steer),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .byte_access (byte_access),
        .hold_data   (hold_data),
        .busy        (busy),
        .done        (done),
        .err         (err)
    );

    ptr_dma_lane u_lane (
        .byte_access (byte_access),
        .addr_lsb    (mem_addr[LSB_W-1:0]),
        .rdata_raw   (mem_rdata),
        .hold_data   (hold_data),
        .be          (mem_be),
        .wdata       (mem_wdata),
        .rdata_steer (rdata_steer)
    );

    // R5: a byte access enables exactly the lane its address selects
    assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) && ($countones(mem_be) == 1) |-> mem_be[mem_addr[LSB_W-1:0]]);

    // R4: a write of a single byte presents it on every lane
    assert_byte_replicated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && ($countones(mem_be) == 1) |-> (mem_wdata[15:8] == mem_wdata[7:0]));

endmodule

// File: tb/ptr_dma_engine_bench.sv
module ptr_dma_engine_bench;

    localparam int MEM_SZ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [15:0] cfg_count = '0;
    logic [1:0]  cfg_size = '0;
    logic        cfg_dst_inc = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ready = 1'b0;
    logic        busy, done, err;

    always #2 clk = ~clk;

    ptr_dma_engine u_ptr_dma_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .cfg_size(cfg_size), .cfg_dst_inc(cfg_dst_inc),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .done(done), .err(err)
    );

    logic [7:0] mem [0:MEM_SZ-1];

    always_comb begin
        mem_rdata = {mem[{mem_addr[11:1], 1'b1}], mem[{mem_addr[11:1], 1'b0}]};
    end

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [1:0]  be;
        logic [15:0] wdata;
        string       tag;
    } acc_t;

    acc_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   rand_ready = 0;
    bit   collide_arm = 0;
    bit   mon_start = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // reference model step: compare the bus with the head of the expected queue
    task automatic monitor_step();
        acc_t h;
        bit   rdy;
        if (mon_start) begin
            start = 1'b0;
            mon_start = 0;
        end
        if (!rst_n) return;
        if (mem_rd || mem_wr) begin
            if (q.size() == 0) begin
                check(0, "R12", "access with nothing expected", mem_addr, 0);
            end else begin
                h = q[0];
                check((mem_wr == h.wr) && (mem_rd == !h.wr), h.tag, "strobe kind",
                      {mem_rd, mem_wr}, {!h.wr, h.wr});
                check(mem_addr == h.addr, h.tag, "address", mem_addr, h.addr);
                check(mem_be == h.be, h.tag, "byte enables", mem_be, h.be);
                if (h.wr) check(mem_wdata == h.wdata, "R4", "write data", mem_wdata, h.wdata);
                check(busy && !done, "R8", "busy/done during run", {busy, done}, 2'b10);
            end
        end
        rdy = rand_ready ? 1'($urandom_range(0, 1)) : 1'b1;
        mem_ready = rdy;
        if (rdy && (mem_rd || mem_wr) && q.size() > 0) begin
            h = q.pop_front();
            if (h.wr) begin
                if (h.be[0]) mem[{h.addr[11:1], 1'b0}] = mem_wdata[7:0];
                if (h.be[1]) mem[{h.addr[11:1], 1'b1}] = mem_wdata[15:8];
            end
            if (q.size() == 0 && collide_arm) begin
                // R12: start arrives on the very edge that accepts the final write
                start = 1'b1;
                cfg_count = 16'd4;
                collide_arm = 0;
                mon_start = 1;
            end
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            monitor_step();
        end
    end

    function automatic logic [31:0] ptr_of(input int i, input bit is_byte);
        return is_byte ? (32'h0001_0800 + 32'(5 * i)) : (32'h0002_0900 + 32'(6 * i));
    endfunction

    task automatic pulse_start();
        @(posedge clk); #1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run_job(input logic [31:0] src, input logic [31:0] dst, input int cnt,
                           input bit is_byte, input bit inc, input bit rnd, input bit disturb,
                           input bit collide);
        logic [31:0] p, s, d;
        logic [15:0] val, got;
        logic [15:0] exp_vals [$];
        logic [31:0] dst_list [$];
        acc_t a;
        rand_ready = rnd;
        d = dst;
        for (int i = 0; i < cnt; i++) begin
            s = src + 32'(4 * i);
            p = ptr_of(i, is_byte);
            mem[s[11:0]]         = p[23:16];
            mem[s[11:0] + 12'd1] = p[31:24];
            mem[s[11:0] + 12'd2] = p[7:0];
            mem[s[11:0] + 12'd3] = p[15:8];
            val = is_byte ? {8'h00, mem[p[11:0]]} : {mem[p[11:0] + 12'd1], mem[p[11:0]]};
            exp_vals.push_back(val);
            dst_list.push_back(d);
            a = '{0, s, 2'b11, 16'h0, (i == 0) ? "R2" : "R6"};
            q.push_back(a);
            a = '{0, s + 32'd2, 2'b11, 16'h0, "R2"};
            q.push_back(a);
            a = '{0, p, is_byte ? (p[0] ? 2'b10 : 2'b01) : 2'b11, 16'h0, is_byte ? "R5" : "R3"};
            q.push_back(a);
            a = '{1, d, is_byte ? (d[0] ? 2'b10 : 2'b01) : 2'b11,
                  is_byte ? {val[7:0], val[7:0]} : val, (i == 0) ? "R4" : "R7"};
            q.push_back(a);
            if (inc) d = d + (is_byte ? 32'd1 : 32'd2);
        end
        collide_arm = collide;
        @(posedge clk); #1;
        cfg_src = src; cfg_dst = dst; cfg_count = 16'(cnt);
        cfg_size = is_byte ? 2'b00 : 2'b01; cfg_dst_inc = inc;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (disturb) begin
            repeat (5) @(posedge clk);
            #1;
            // R12: a second start with other settings must change nothing
            cfg_src = 32'h0000_0F00; cfg_dst = 32'h0000_0010; cfg_size = 2'b11;
            cfg_count = 16'd9; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (q.size() != 0) @(posedge clk);
        @(negedge clk);
        #0.5;
        check(done && !busy, "R8", "done after last write", {done, busy}, 2'b10);
        check(!err, "R12", "no error from ignored inputs", err, 0);
        repeat (2) @(negedge clk);
        check(!busy && !mem_rd && !mem_wr, "R12", "stays idle after run",
              {busy, mem_rd, mem_wr}, 0);
        check(done, "R8", "done holds", done, 1);
        for (int i = 0; i < cnt; i++) begin
            if (inc || i == cnt - 1) begin
                d = dst_list[i];
                got = is_byte ? {8'h00, mem[d[11:0]]} : {mem[d[11:0] + 12'd1], mem[d[11:0]]};
                check(got == exp_vals[i], inc ? "R4" : "R7", "destination content",
                      got, exp_vals[i]);
            end
        end
    endtask

    task automatic bad_size(input logic [1:0] code);
        @(posedge clk); #1;
        cfg_size = code; cfg_count = 16'd3; cfg_src = 32'h100; cfg_dst = 32'hC00;
        pulse_start();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #0.5;
            check(!mem_rd && !mem_wr && !busy, "R10", "no access on bad size",
                  {mem_rd, mem_wr, busy}, 0);
        end
        check(err && !done, "R10", "err set, done clear", {err, done}, 2'b10);
    endtask

    initial begin
        for (int a = 0; a < MEM_SZ; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 8));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #0.5;
        check({mem_rd, mem_wr, busy, done, err} == 5'b0, "R1", "reset state",
              {mem_rd, mem_wr, busy, done, err}, 0);

        run_job(32'h100, 32'hC00, 3, 0, 1, 0, 0, 0);
        run_job(32'h200, 32'hC40, 5, 1, 1, 1, 0, 0);
        run_job(32'h300, 32'hC80, 2, 0, 0, 1, 0, 0);
        run_job(32'h340, 32'hCC1, 4, 1, 0, 1, 0, 0);
        run_job(32'h380, 32'hD01, 3, 1, 1, 0, 0, 0);

        bad_size(2'b11);
        bad_size(2'b10);
        run_job(32'h400, 32'hD40, 2, 0, 1, 1, 0, 0);
        check(!err, "R10", "err cleared by next start", err, 0);

        @(posedge clk); #1;
        cfg_count = 16'd0; cfg_size = 2'b01;
        pulse_start();
        @(negedge clk); #0.5;
        check(done && !busy && !mem_rd && !mem_wr, "R11", "zero count completes",
              {done, busy, mem_rd, mem_wr}, 4'b1000);

        run_job(32'h500, 32'hD80, 4, 0, 1, 1, 1, 0);
        run_job(32'h600, 32'hDC0, 3, 1, 1, 1, 1, 0);
        run_job(32'h700, 32'hE00, 2, 0, 1, 0, 0, 1);
        run_job(32'h740, 32'hE40, 3, 1, 1, 1, 0, 1);

        finish_run();
    end

    initial begin
        #(4 * 150000);
        check(0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

endmodule